// File: doc/BRIEF.md
# Boot Partition Access Range Checker

This block sits between a command decoder and the media back end of a managed flash device. Every block of a single-block or multi-block read or write that targets the currently selected region comes in as a request. The block answers each one, a cycle later, with a permit or deny decision and the physical sector address. The region is either the user area or one of two boot partitions. Each boot partition is sized at run time as a multiple of 128 KB. A block that would land past the end of its boot partition is refused. A sticky out-of-range flag records that this happened until status is read.

Only the first block of a command carries an address. The block tracks the later blocks of a multi-block command itself, advancing one sector per block. Blocks inside the partition are passed through. Once one block is refused, the rest of that command is refused as well. The physical layout puts boot partition 1 at sector 0, boot partition 2 directly after it, and the user area after both.

Top module: `bpr_range_check`

## Requirements
- R1: Each accepted request produces resp_valid high exactly one clock later. Without an accepted request, resp_valid is low in the following cycle.
- R2: part_sel = 000 selects the user area. Every block there is permitted, with resp_addr = 2*S + offset, where S = size_mult*256 sectors.
- R3: part_sel = 001 selects boot partition 1, whose base sector is 0. part_sel = 010 selects boot partition 2, whose base sector is S. The values 011 to 111 are refused.
- R4: With sector_mode = 1, req_addr is a sector number. With sector_mode = 0, req_addr is a byte address and the offset is req_addr >> 9, so the low 9 bits are ignored.
- R5: A boot-partition block is permitted only when offset < S. A permitted block reports base + offset on resp_addr. A refused block reports resp_permit = 0 and resp_addr = 0.
- R6: A command started with req_start = 1 and req_multi = 1 accepts continuation requests (req_start = 0), each at the next sector. After the first refused block, every later block of that command is refused, even if the configuration changes.
- R7: A continuation request is ignored when no multi-block command is open, for example after a single-block start or after reset. No response follows it.
- R8: A refused block sets oor_err on the same edge as its response. oor_err holds until an err_clear pulse. If a refusal and err_clear arrive in the same cycle, the flag stays set.
- R9: size_mult = 0 marks both boot partitions as absent, so every boot-partition access is refused. The user area then starts at sector 0.
- R10: During and after reset, resp_valid, resp_permit, resp_addr and oor_err are 0 and no command is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| part_sel | input | 3 | Partition-access field: 000 user, 001 boot 1, 010 boot 2 |
| size_mult | input | 8 | Boot partition size in 128 KB units |
| sector_mode | input | 1 | 1: addresses are sectors, 0: addresses are bytes |
| req_valid | input | 1 | A block request is present |
| req_start | input | 1 | First block of a command; req_addr is valid |
| req_multi | input | 1 | Command is multi-block (sampled with req_start) |
| req_addr | input | 32 | Start address of the command |
| err_clear | input | 1 | Clears oor_err (status read) |
| resp_valid | output | 1 | Decision valid |
| resp_permit | output | 1 | Block may be transferred |
| resp_addr | output | 33 | Physical sector address, 0 when refused |
| oor_err | output | 1 | Sticky out-of-range error |

## Verification
Two events can land on the same edge: the sticky error flag being set by a refused block, and the flag being cleared by a status-read pulse. The bench runs a multi-block command past the end of boot partition 2 and raises err_clear in the very cycle that a refused continuation is presented. It then expects oor_err to be still high. A later err_clear with no request present must drop the flag, which shows that the earlier clear was overridden rather than lost.

// File: rtl/bpr_pkg.sv
// Shared types for the boot partition range checker.
package bpr_pkg;
    // Region addressed by the partition-access field.
    typedef enum logic [1:0] {
        RGN_USER  = 2'd0,
        RGN_BOOT1 = 2'd1,
        RGN_BOOT2 = 2'd2,
        RGN_BAD   = 2'd3
    } region_e;
endpackage

// File: rtl/bpr_geometry.sv
// Decodes the partition-access field and the size multiplier into a region,
// a base sector and a sector limit. Purely combinational.
// Assumes PA_W is wide enough to hold twice the largest partition size.
module bpr_geometry
    import bpr_pkg::*;
#(
    parameter int MULT_W    = 8,
    parameter int UNIT_LOG2 = 8,
    parameter int PA_W      = 33
) (
    input  logic [2:0]        sel,
    input  logic [MULT_W-1:0] mult,
    output region_e           region,
    output logic [PA_W-1:0]   base,
    output logic [PA_W-1:0]   limit
);
    logic [PA_W-1:0] size_sect;

    // Partition size in sectors: multiplier times sectors per unit.
    always_comb size_sect = {{(PA_W-MULT_W){1'b0}}, mult} << UNIT_LOG2;

    // Region, base and limit for the selected field value.
    always_comb begin
        unique case (sel)
            3'b000: begin
                region = RGN_USER;
                base   = size_sect << 1;
                limit  = '0;
            end
            3'b001: begin
                region = RGN_BOOT1;
                base   = '0;
                limit  = size_sect;
            end
            3'b010: begin
                region = RGN_BOOT2;
                base   = size_sect;
                limit  = size_sect;
            end
            default: begin
                region = RGN_BAD;
                base   = '0;
                limit  = '0;
            end
        endcase
    end
endmodule

// File: rtl/bpr_cursor.sv
// Holds the per-command state: whether a multi-block command is open,
// the sector offset of its next block, and whether it has had a refusal.
// Assumes the caller asserts accept only for requests it will answer.
module bpr_cursor #(
    parameter int PA_W = 33
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            start,
    input  logic            multi,
    input  logic            deny,
    input  logic [PA_W-1:0] offset_in,
    output logic            open_multi,
    output logic            dead,
    output logic [PA_W-1:0] next_off
);
    // Advance the offset and track the refusal state per accepted block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_multi <= 1'b0;
            dead       <= 1'b0;
            next_off   <= '0;
        end else if (accept) begin
            next_off <= offset_in + 1'b1;
            if (start) begin
                open_multi <= multi;
                dead       <= deny;
            end else begin
                dead <= dead | deny;
            end
        end
    end
endmodule

// File: rtl/bpr_err_flag.sv
// Sticky error flag: a set wins over a clear in the same cycle.
module bpr_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Set on refusal, drop on status read.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/bpr_range_check.sv
// Boot partition range checker. It translates each block request into a
// physical sector address and permits or refuses it against the end of the
// selected boot partition. The response is registered, one cycle after the request.
// Layout: boot 1 at sector 0, boot 2 at S, user area at 2*S.
// Assumes part_sel and size_mult are driven by configuration state. They are
// sampled on every block, so the sticky refusal covers changes made mid-command.
module bpr_range_check
    import bpr_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int MULT_W       = 8,
    parameter int SECTOR_BYTES = 512,
    parameter int UNIT_BYTES   = 131072
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        part_sel,
    input  logic [MULT_W-1:0] size_mult,
    input  logic              sector_mode,
    input  logic              req_valid,
    input  logic              req_start,
    input  logic              req_multi,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              err_clear,
    output logic              resp_valid,
    output logic              resp_permit,
    output logic [ADDR_W:0]   resp_addr,
    output logic              oor_err
);
    localparam int SECT_LOG2 = $clog2(SECTOR_BYTES);
    localparam int UNIT_LOG2 = $clog2(UNIT_BYTES / SECTOR_BYTES);
    localparam int PA_W      = ADDR_W + 1;

    region_e         region;
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] limit;
    logic            open_multi;
    logic            dead;
    logic [PA_W-1:0] next_off;
    logic [PA_W-1:0] start_off;
    logic [PA_W-1:0] offset;
    logic            accept;
    logic            in_range;
    logic            permit_d;
    logic            deny;

    bpr_geometry #(
        .MULT_W    (MULT_W),
        .UNIT_LOG2 (UNIT_LOG2),
        .PA_W      (PA_W)
    ) i_geom (
        .sel    (part_sel),
        .mult   (size_mult),
        .region (region),
        .base   (base),
        .limit  (limit)
    );

    // A start is always taken; a continuation only inside an open multi command.
    always_comb accept = req_valid & (req_start | open_multi);

    // Start offset in sectors from either addressing mode.
    always_comb start_off = sector_mode ? PA_W'(req_addr) : PA_W'(req_addr >> SECT_LOG2);

    // Offset of the block being decided.
    always_comb offset = req_start ? start_off : next_off;

    // Boundary test for the selected region.
    always_comb begin
        unique case (region)
            RGN_USER:            in_range = 1'b1;
            RGN_BOOT1, RGN_BOOT2: in_range = (offset < limit);
            default:             in_range = 1'b0;
        endcase
    end

    // Permit needs range and no earlier refusal in this command.
    always_comb begin
        permit_d = in_range & (req_start | ~dead);
        deny     = accept & ~permit_d;
    end

    bpr_cursor #(
        .PA_W (PA_W)
    ) i_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .start      (req_start),
        .multi      (req_multi),
        .deny       (deny),
        .offset_in  (offset),
        .open_multi (open_multi),
        .dead       (dead),
        .next_off   (next_off)
    );

    bpr_err_flag i_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (deny),
        .clr   (err_clear),
        .flag  (oor_err)
    );

    // Registered decision and physical address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_permit <= 1'b0;
            resp_addr   <= '0;
        end else begin
            resp_valid  <= accept;
            resp_permit <= accept & permit_d;
            resp_addr   <= (accept & permit_d) ? (base + offset) : '0;
        end
    end
endmodule

// File: rtl/bpr_range_check_sva.sv
// Property checker for bpr_range_check, attached by bind. It watches ports
// only, and tracks from the outputs whether the open command has had a refusal.
module bpr_range_check_sva #(
    parameter int ADDR_W = 32,
    parameter int MULT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        part_sel,
    input logic [MULT_W-1:0] size_mult,
    input logic              req_valid,
    input logic              req_start,
    input logic              err_clear,
    input logic              resp_valid,
    input logic              resp_permit,
    input logic [ADDR_W:0]   resp_addr,
    input logic              oor_err
);
    logic seen_deny;

    // Refusal seen in the current command, as observed on the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)                      seen_deny <= 1'b0;
        else if (req_valid && req_start) seen_deny <= 1'b0;
        else if (resp_valid && !resp_permit) seen_deny <= 1'b1;
    end

    a_r1_start_answered: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_start |=> resp_valid);
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    a_r2_user_permit: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_start && part_sel == 3'b000 |=> resp_permit);
    a_r5_deny_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_permit |-> resp_addr == '0);
    a_r6_kill_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_deny || (resp_valid && !resp_permit)) && req_valid && !req_start
        |=> !resp_permit);
    a_r8_set_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_permit |-> oor_err);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        oor_err && !err_clear |=> oor_err);
    a_r9_absent: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_start && size_mult == '0 && part_sel != 3'b000
        |=> resp_valid && !resp_permit);
    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> !resp_valid && !resp_permit && !oor_err);
endmodule

bind bpr_range_check bpr_range_check_sva #(
    .ADDR_W (ADDR_W),
    .MULT_W (MULT_W)
) i_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .part_sel    (part_sel),
    .size_mult   (size_mult),
    .req_valid   (req_valid),
    .req_start   (req_start),
    .err_clear   (err_clear),
    .resp_valid  (resp_valid),
    .resp_permit (resp_permit),
    .resp_addr   (resp_addr),
    .oor_err     (oor_err)
);

// File: tb/test_bpr_range_check.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module test_bpr_range_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  part_sel = 3'b000;
    logic [7:0]  size_mult = 8'd0;
    logic        sector_mode = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_start = 1'b0;
    logic        req_multi = 1'b0;
    logic [31:0] req_addr = '0;
    logic        err_clear = 1'b0;
    logic        resp_valid;
    logic        resp_permit;
    logic [32:0] resp_addr;
    logic        oor_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bpr_range_check i_bpr_range_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .part_sel    (part_sel),
        .size_mult   (size_mult),
        .sector_mode (sector_mode),
        .req_valid   (req_valid),
        .req_start   (req_start),
        .req_multi   (req_multi),
        .req_addr    (req_addr),
        .err_clear   (err_clear),
        .resp_valid  (resp_valid),
        .resp_permit (resp_permit),
        .resp_addr   (resp_addr),
        .oor_err     (oor_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present one request cycle; return at the next falling edge, response visible.
    task automatic step(input logic v, input logic st, input logic mu,
                        input logic [31:0] a, input logic clr);
        @(negedge clk);
        req_valid = v; req_start = st; req_multi = mu; req_addr = a; err_clear = clr;
        @(negedge clk);
        req_valid = 1'b0; req_start = 1'b0; err_clear = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10 resp_valid", resp_valid, 0);
        chk("R10 resp_addr", resp_addr, 0);
        chk("R10 oor_err", oor_err, 0);
        step(1, 0, 0, 0, 0);                // continuation with nothing open
        chk("R7 no response after reset", resp_valid, 0);
    endtask

    task automatic t_user;
        part_sel = 3'b000; size_mult = 8'd2; sector_mode = 1'b1;
        step(1, 1, 0, 32'd100, 0);
        chk("R1 valid", resp_valid, 1);
        chk("R2 permit", resp_permit, 1);
        chk("R2 addr", resp_addr, 1124);
        step(0, 0, 0, 0, 0);
        chk("R1 quiet", resp_valid, 0);
        sector_mode = 1'b0;
        step(1, 1, 0, 32'd2577, 0);         // byte 2577 -> sector 5
        chk("R4 byte addr", resp_addr, 1029);
        sector_mode = 1'b1;
    endtask

    task automatic t_boot_edges;
        size_mult = 8'd2; part_sel = 3'b001;
        step(1, 1, 0, 32'd511, 0);
        chk("R5 last sector permit", resp_permit, 1);
        chk("R5 last sector addr", resp_addr, 511);
        step(1, 1, 0, 32'd512, 0);
        chk("R5 past end refused", resp_permit, 0);
        chk("R5 refused addr", resp_addr, 0);
        chk("R8 flag set", oor_err, 1);
        step(0, 0, 0, 0, 0);
        chk("R8 flag holds", oor_err, 1);
        step(0, 0, 0, 0, 1);
        chk("R8 flag cleared", oor_err, 0);
        part_sel = 3'b010;
        step(1, 1, 0, 32'd0, 0);
        chk("R3 boot2 base", resp_addr, 512);
        part_sel = 3'b011;
        step(1, 1, 0, 32'd0, 0);
        chk("R3 reserved refused", resp_permit, 0);
        step(0, 0, 0, 0, 1);
    endtask

    task automatic t_multi;
        part_sel = 3'b010; size_mult = 8'd1;
        step(1, 1, 1, 32'd254, 0);
        chk("R6 first block", resp_addr, 510);
        step(1, 0, 0, 0, 0);
        chk("R6 second block", resp_addr, 511);
        chk("R6 second permit", resp_permit, 1);
        chk("R8 no flag inside", oor_err, 0);
        step(1, 0, 0, 0, 0);
        chk("R6 boundary refused", resp_permit, 0);
        chk("R6 boundary valid", resp_valid, 1);
        size_mult = 8'd4;
        step(1, 0, 0, 0, 1);                // refusal and clear together
        chk("R6 sticky refusal", resp_permit, 0);
        chk("R8 set wins over clear", oor_err, 1);
        step(0, 0, 0, 0, 1);
        chk("R8 lone clear", oor_err, 0);
    endtask

    task automatic t_single_ignore;
        part_sel = 3'b001; size_mult = 8'd4;
        step(1, 1, 0, 32'd3, 0);
        chk("R3 boot1 addr", resp_addr, 3);
        step(1, 0, 0, 0, 0);
        chk("R7 continuation ignored", resp_valid, 0);
        chk("R7 flag untouched", oor_err, 0);
    endtask

    task automatic t_absent;
        size_mult = 8'd0; part_sel = 3'b001;
        step(1, 1, 0, 32'd0, 0);
        chk("R9 absent refused", resp_permit, 0);
        chk("R9 flag", oor_err, 1);
        step(0, 0, 0, 0, 1);
        part_sel = 3'b000;
        step(1, 1, 0, 32'd7, 0);
        chk("R9 user at zero", resp_addr, 7);
        chk("R9 user permit", resp_permit, 1);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre: begin
            chk("R10 resp_permit in reset", resp_permit, 0);
        end
        rst_n = 1'b1;
        t_reset;
        t_user;
        t_boot_edges;
        t_multi;
        t_single_ignore;
        t_absent;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule